// File: doc/BRIEF.md
# Duty-Cycled Magnetic Switch Sampling Sequencer

This block saves power in a magnetic switch front end. Once per wake period it powers the sensor bias for a short window. At the last cycle of that window it samples the digitised switch decision, and it holds that result on an active-low switch output. For the rest of the period the sensor is off. The block keeps the sensor powered all the time while the latched output is asserted, or while an external active-low LED enable is held low. In that mode the output tracks the decision through a two-flop synchroniser.

Both timing values are parameters counted in clock cycles. At a 100 MHz clock, the defaults give a 50 ms period and a 50 µs window. The sample strobe marks every windowed latch event, so the window timing can be observed from outside.

Top module: `hall_duty_sequencer`

## Requirements
- R1: With the output high and the enable high, `sensor_pwr` is high for exactly AWAKE_CYC cycles and then low for PERIOD_CYC minus AWAKE_CYC cycles. This pattern repeats every PERIOD_CYC cycles.
- R2: `sample_stb` pulses for one cycle in the last cycle of each duty-cycled awake window. On the following clock edge, `sw_out_n` takes the inverse of the synchronised decision, where `sense_raw` = 1 means a field beyond the operate point and drives `sw_out_n` low.
- R3: While `sw_out_n` is high and the block is duty-cycling, `sw_out_n` stays high through the sleep interval, whatever `sense_raw` does. It can only fall at the end of an awake window.
- R4: While `sw_out_n` is low, `sensor_pwr` stays high. `sw_out_n` returns high on the third clock edge after `sense_raw` drops to 0.
- R5: While `led_en_n` is low, `sensor_pwr` stays high. Once the first sample has been taken, `sw_out_n` follows the decision with the same three-edge latency.
- R6: During reset `sw_out_n` is high and `sample_stb` is low. The first cycle after reset opens an awake window, whose sample comes before any sleep interval.
- R7: Until the first windowed sample, `sw_out_n` stays high, even when `sense_raw` is 1 and `led_en_n` is low.
- R8: When continuous-awake operation ends, the period count restarts from zero. A full window of AWAKE_CYC powered cycles, ending with a strobe, follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense_raw | input | 1 | Digitised switch decision, 1 = field beyond operate point |
| led_en_n | input | 1 | Active-low LED enable; low holds the sensor awake |
| sensor_pwr | output | 1 | Sensor bias enable |
| sw_out_n | output | 1 | Latched active-low switch output |
| sample_stb | output | 1 | One-cycle pulse at each windowed sample |

## Verification
The assertions assume that `led_en_n` is synchronous to `clk`, because it feeds the power and hold logic without a synchroniser. They also assume that AWAKE_CYC is at least 1 and below PERIOD_CYC. `sense_raw` may change at any time, since it passes through the synchroniser. The stimulus changes both inputs only on falling clock edges, so they are always stable at the rising edge. The bench runs a short period and window, so every sleep interval and every strobe stays inside the check window.

// File: rtl/hall_duty_sequencer.sv
module hall_duty_sequencer #(
  parameter int unsigned PERIOD_CYC = 5_000_000,
  parameter int unsigned AWAKE_CYC  = 5_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_raw,
  input  logic led_en_n,
  output logic sensor_pwr,
  output logic sw_out_n,
  output logic sample_stb
);

  localparam int unsigned CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST_AWAKE = CW'(AWAKE_CYC - 1);
  localparam logic [CW-1:0] LAST_SLOT  = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] slot;
  logic          sync_a, sync_b;
  logic          primed;
  logic          hold_awake;
  logic          in_window;

  assign hold_awake = primed & (~sw_out_n | ~led_en_n);
  assign in_window  = (32'(slot) < AWAKE_CYC);
  assign sensor_pwr = in_window | hold_awake | ~led_en_n;
  assign sample_stb = ~hold_awake & (slot == LAST_AWAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= sense_raw;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot     <= '0;
      primed   <= 1'b0;
      sw_out_n <= 1'b1;
    end else if (hold_awake) begin
      slot     <= '0;
      sw_out_n <= ~sync_b;
    end else begin
      slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
      if (sample_stb) begin
        sw_out_n <= ~sync_b;
        primed   <= 1'b1;
      end
    end
  end

  AST_WAKE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sensor_pwr && slot == LAST_SLOT) |=> sensor_pwr); // R1
  AST_STB_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> sensor_pwr); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb); // R2
  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && sw_out_n && led_en_n && !sample_stb) |=> sw_out_n); // R3
  AST_ACTIVE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_out_n |-> sensor_pwr); // R4
  AST_EN_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !led_en_n |-> sensor_pwr); // R5
  AST_PRE_PRIME_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> sw_out_n); // R7

endmodule

// File: tb/test_hall_duty_sequencer.sv
`timescale 1ns/1ps
module test_hall_duty_sequencer;
  localparam int P = 20;
  localparam int A = 4;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sense_raw = 1'b0;
  logic led_en_n = 1'b1;
  logic sensor_pwr, sw_out_n, sample_stb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hall_duty_sequencer #(.PERIOD_CYC(P), .AWAKE_CYC(A)) i_hall_duty_sequencer (
    .clk(clk), .rst_n(rst_n), .sense_raw(sense_raw), .led_en_n(led_en_n),
    .sensor_pwr(sensor_pwr), .sw_out_n(sw_out_n), .sample_stb(sample_stb)
  );

  // sense, en_n, edges to advance, exp sw_out_n, exp sensor_pwr, exp sample_stb, req
  localparam int VEC [NV][7] = '{
    '{1,1, 3,1,1,1,2},  // R2 R7 first strobe, output still high
    '{1,1, 1,0,1,0,2},  // R2 latched low
    '{1,1,12,0,1,0,4},  // R4 stays awake while active
    '{0,1, 2,0,1,0,4},  // R4 two edges: not yet
    '{0,1, 1,1,1,0,4},  // R4 third edge releases
    '{0,1, 3,1,1,1,8},  // R8 fresh window strobe
    '{0,1, 1,1,0,0,1},  // R1 asleep
    '{1,1,10,1,0,0,3},  // R3 decision ignored in sleep
    '{1,1, 5,1,0,0,3},  // R3 last sleep slot
    '{1,1, 1,1,1,0,1},  // R1 wake at wrap
    '{1,1, 3,1,1,1,2},  // R2 strobe
    '{1,1, 1,0,1,0,2},  // R2 latch active
    '{1,0, 5,0,1,0,5},  // R5 enable low
    '{0,0, 3,1,1,0,5},  // R5 follows release
    '{1,0, 3,0,1,0,5},  // R5 follows operate
    '{0,0, 3,1,1,0,5},  // R5 follows release
    '{0,0,10,1,1,0,5},  // R5 awake with output high
    '{0,1, 1,1,1,0,8},  // R8 counting from zero
    '{0,1, 1,1,1,0,8},  // R8 slot two
    '{0,1, 1,1,1,1,8},  // R8 strobe at window end
    '{0,1, 1,1,0,0,1},  // R1 sleep
    '{0,1,16,1,1,0,1}   // R1 next period
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string what, input int req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int stb_cnt;
    int pwr_cnt;
    sense_raw = 1'b1;
    led_en_n  = 1'b1;
    rst_n     = 1'b0;
    tick(3);
    chk("R6 out in reset", 6, sw_out_n, 1'b1);
    chk("R6 stb in reset", 6, sample_stb, 1'b0);
    rst_n = 1'b1;
    chk("R6 window opens", 6, sensor_pwr, 1'b1);

    for (int v = 0; v < NV; v++) begin
      sense_raw = VEC[v][0][0];
      led_en_n  = VEC[v][1][0];
      tick(VEC[v][2]);
      chk($sformatf("row %0d out", v), VEC[v][6], sw_out_n, VEC[v][3][0]);
      chk($sformatf("row %0d pwr", v), VEC[v][6], sensor_pwr, VEC[v][4][0]);
      chk($sformatf("row %0d stb", v), VEC[v][6], sample_stb, VEC[v][5][0]);
    end

    // R7: decision active and enable low from reset; output held high until first sample
    rst_n = 1'b0;
    sense_raw = 1'b1;
    led_en_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2);
    chk("R7 held high before sample", 7, sw_out_n, 1'b1);
    chk("R7 powered", 7, sensor_pwr, 1'b1);
    tick(1);
    chk("R7 first strobe", 7, sample_stb, 1'b1);
    chk("R7 still high at strobe", 7, sw_out_n, 1'b1);
    tick(1);
    chk("R7 latched after strobe", 7, sw_out_n, 1'b0);

    // R1 R2: three periods of plain duty cycling
    rst_n = 1'b0;
    sense_raw = 1'b0;
    led_en_n = 1'b1;
    tick(2);
    rst_n = 1'b1;
    stb_cnt = 0;
    pwr_cnt = 0;
    for (int k = 0; k < 3 * P; k++) begin
      stb_cnt += int'(sample_stb);
      pwr_cnt += int'(sensor_pwr);
      tick(1);
    end
    checks++;
    if (stb_cnt != 3) begin
      failures++;
      $display("FAIL R2 strobe count actual=%0d expected=%0d", stb_cnt, 3);
    end
    checks++;
    if (pwr_cnt != 3 * A) begin
      failures++;
      $display("FAIL R1 powered cycles actual=%0d expected=%0d", pwr_cnt, 3 * A);
    end
    chk("R3 output stays high", 3, sw_out_n, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule